// File: doc/BRIEF.md
# Edge-Event Interrupt Status Unit

This unit gathers up to eight event lines from a serial link controller into one interrupt status register. An event line sets its status bit on a rising transition only. A bit stays set while its line stays high, but that line does not set it again until the line has fallen and risen once more. Every transition is recorded whether or not it is enabled. A separate enable register picks which recorded events drive the active-high `irq` output.

Software reads the status through a small register port. A read strobe addressed to the status location starts a read cycle. The captured value appears on `rdata` one cycle later, and `irq` goes low at that same edge. The read cycle lasts while `rd_active` stays high. When it ends, the status register clears. A transition that arrives on a clear bit during the read is held back rather than lost, and it is merged into the status register on the cycle after the clear. A transition on a bit that was already set when the read began is absorbed by that read. Writes to the status location have no effect. A synchronous `soft_rst` returns the unit to its power-on state.

The control is a three-state read sequencer:
- `ST_IDLE`: normal capture. Its only exit, `start_read`, is taken on a status read strobe.
- `ST_HOLD`: the read is in progress. Events are deferred here. The transition `finish_read` is taken when `rd_active` is sampled low; it clears the status register.
- `ST_POST`: the deferred events are merged in. The transition `merged` returns to `ST_IDLE` unconditionally.

Top module: `irq_event_hub`

## Requirements
- R1: After `rst_n` is released, the enable register reads 0, the status register reads 0 and `irq` is low.
- R2: A rising transition on an event line sets its status bit even when that bit is not enabled; a disabled bit never raises `irq`.
- R3: A status bit is set only by a 0-to-1 transition on its line: a line held high sets the bit once, and after the bit is cleared it stays clear while the line remains high.
- R4: Outside a status read cycle, `irq` equals the OR of (status AND enable); it reflects a new event or an enable write from the clock edge that stores it.
- R5: A read strobe with `addr` equal to the status address (4'h3) while idle loads `rdata` at the next edge with the status including that cycle's transitions, and `irq` is low from that edge until the read cycle is over.
- R6: At the first edge where `rd_active` is sampled low during a read cycle, the status register clears; `irq` stays low in the following cycle.
- R7: A transition on a clear status bit during a read cycle is held, and it appears in the status register one edge after the clear, raising `irq` again if it is enabled.
- R8: A transition during a read cycle on a bit that was already set when the read began is dropped; it is not posted after the read.
- R9: A write to the enable address (4'h2) loads the enable register, and a read strobe to 4'h2 returns it on `rdata` at the next edge; writes to the status address change nothing.
- R10: `soft_rst` clears the enable and status registers and any held events, and ends a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset of all registers |
| evt_in | input | 8 | Event condition lines, captured on rising transition |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (command/address phase) |
| addr | input | 4 | Register address (4'h2 enable, 4'h3 status) |
| wdata | input | 8 | Write data |
| rd_active | input | 1 | High while the status read cycle is in progress |
| rdata | output | 8 | Read data, loaded one edge after a read strobe |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that `rd_active` has a meaning only after a status read strobe. They also assume that `evt_in` carries levels, so a capture is a transition between sampled values, and that a status read strobe is not reissued while a read cycle is still running. The stimulus holds `rd_active` high from the command cycle through at least one further cycle and drives every strobe as a single-cycle pulse at the falling edge. It issues a status read again only after the sequencer has had two more edges to return to idle. Events are placed in the command cycle, inside the read window and after it, to reach both the deferred path and the absorbed path.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int EVT_N  = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ENABLE_ADDR = 4'h2;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 4'h3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_POST = 2'd2
    } rd_state_e;

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] lvl_q;

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lvl_q[b] <= 1'b0;
                end else begin
                    lvl_q[b] <= lvl_i[b];
                end
            end

            assign rise_o[b] = lvl_i[b] & ~lvl_q[b];
        end
    endgenerate

endmodule

// File: rtl/irq_read_fsm.sv
module irq_read_fsm
    import irq_hub_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      soft_rst,
    input  logic      stat_rd_i,
    input  logic      rd_active_i,
    output logic      in_idle_o,
    output logic      in_hold_o,
    output logic      start_rd_o,
    output logic      clr_stat_o,
    output logic      post_pend_o,
    output rd_state_e state_o
);

    rd_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (soft_rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        in_idle_o   = 1'b0;
        in_hold_o   = 1'b0;
        start_rd_o  = 1'b0;
        clr_stat_o  = 1'b0;
        post_pend_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_idle_o = 1'b1;
                if (stat_rd_i) begin
                    start_rd_o = 1'b1;
                    state_d    = ST_HOLD;
                end
            end
            ST_HOLD: begin
                in_hold_o = 1'b1;
                if (!rd_active_i) begin
                    clr_stat_o = 1'b1;
                    state_d    = ST_POST;
                end
            end
            ST_POST: begin
                post_pend_o = 1'b1;
                state_d     = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign state_o = state_q;

    // R6
    hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !rd_active_i && !soft_rst) |=> (state_q == ST_POST));

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_hub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [WIDTH-1:0] rise_i,
    input  logic             in_idle_i,
    input  logic             in_hold_i,
    input  logic             start_rd_i,
    input  logic             clr_stat_i,
    input  logic             post_pend_i,
    input  logic             en_wr_i,
    input  logic             en_rd_i,
    input  logic             stat_wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] status_o,
    output logic [WIDTH-1:0] enable_o,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] status_q, status_d;
    logic [WIDTH-1:0] pend_q, pend_d;
    logic [WIDTH-1:0] enable_q;
    logic [WIDTH-1:0] rdata_q;

    // status and held-event update
    always_comb begin
        status_d = status_q;
        pend_d   = pend_q;
        if (in_idle_i) begin
            status_d = status_q | rise_i;
        end else if (in_hold_i) begin
            pend_d = pend_q | (rise_i & ~status_q);
            if (clr_stat_i) begin
                status_d = '0;
            end
        end else if (post_pend_i) begin
            status_d = pend_q | rise_i;
            pend_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            pend_q   <= '0;
        end else if (soft_rst) begin
            status_q <= '0;
            pend_q   <= '0;
        end else begin
            status_q <= status_d;
            pend_q   <= pend_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (soft_rst) begin
            enable_q <= '0;
        end else if (en_wr_i) begin
            enable_q <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (start_rd_i) begin
            rdata_q <= status_q | rise_i;
        end else if (en_rd_i) begin
            rdata_q <= enable_q;
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign rdata_o  = rdata_q;

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle_i && !soft_rst) |=> ((status_q & $past(rise_i)) == $past(rise_i)));

    // R8
    pend_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_hold_i |-> ((pend_q & status_q) == '0));

    // R9
    enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr_i && !soft_rst) |=> (enable_q == $past(wdata_i)));

    // R9
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && in_idle_i && rise_i == '0 && !soft_rst) |=> (status_q == $past(status_q)));

    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (enable_q == '0 && status_q == '0 && pend_q == '0));

endmodule

// File: rtl/irq_event_hub.sv
module irq_event_hub
    import irq_hub_pkg::*;
#(
    parameter int                 N_EVT  = EVT_N,
    parameter int                 A_W    = ADDR_W,
    parameter logic [A_W-1:0]     EN_AD  = ENABLE_ADDR,
    parameter logic [A_W-1:0]     ST_AD  = STATUS_ADDR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [N_EVT-1:0] evt_in,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [A_W-1:0]   addr,
    input  logic [N_EVT-1:0] wdata,
    input  logic             rd_active,
    output logic [N_EVT-1:0] rdata,
    output logic             irq
);

    logic [N_EVT-1:0] rise;
    logic [N_EVT-1:0] status;
    logic [N_EVT-1:0] enable;
    logic             in_idle, in_hold, start_rd, clr_stat, post_pend;
    logic             stat_rd, stat_wr, en_wr, en_rd;
    rd_state_e        state;

    assign stat_rd = rd_en & (addr == ST_AD);
    assign stat_wr = wr_en & (addr == ST_AD);
    assign en_wr   = wr_en & (addr == EN_AD);
    assign en_rd   = rd_en & (addr == EN_AD);

    irq_edge_det #(
        .WIDTH (N_EVT)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (evt_in),
        .rise_o (rise)
    );

    irq_read_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .stat_rd_i   (stat_rd),
        .rd_active_i (rd_active),
        .in_idle_o   (in_idle),
        .in_hold_o   (in_hold),
        .start_rd_o  (start_rd),
        .clr_stat_o  (clr_stat),
        .post_pend_o (post_pend),
        .state_o     (state)
    );

    irq_status_bank #(
        .WIDTH (N_EVT)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .rise_i      (rise),
        .in_idle_i   (in_idle),
        .in_hold_i   (in_hold),
        .start_rd_i  (start_rd),
        .clr_stat_i  (clr_stat),
        .post_pend_i (post_pend),
        .en_wr_i     (en_wr),
        .en_rd_i     (en_rd),
        .stat_wr_i   (stat_wr),
        .wdata_i     (wdata),
        .status_o    (status),
        .enable_o    (enable),
        .rdata_o     (rdata)
    );

    assign irq = in_idle & (|(status & enable));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && state == ST_IDLE && !soft_rst) |=> !irq);

    // R6
    post_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POST) |-> (!irq && status == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq);

endmodule

// File: tb/irq_event_hub_test.sv
`timescale 1ns/1ps
module irq_event_hub_test;

    localparam logic [3:0] EN_A = 4'h2;
    localparam logic [3:0] ST_A = 4'h3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic [7:0] evt_in = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rd_active = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    irq_event_hub uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .evt_in    (evt_in),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rd_active (rd_active),
        .rdata     (rdata),
        .irq       (irq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: irq actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data after the capture edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: rdata actual %02h expected %02h", t, rdata, e);
                end
            end
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, input logic [7:0] e, input string tag);
        rd_en = 1'b1;
        addr  = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        tick();
        rd_en = 1'b0;
    endtask

    task automatic status_read(input logic [7:0] e, input string tag);
        rd_en     = 1'b1;
        rd_active = 1'b1;
        addr      = ST_A;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        tick();
        rd_en = 1'b0;
        check_bit(irq, 1'b0, "R5 irq low in read");
        tick();
        rd_active = 1'b0;
        tick();
        tick();
    endtask

    task automatic pulse(input logic [7:0] b);
        evt_in = b;
        tick();
        evt_in = '0;
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check_bit(irq, 1'b0, "R1 irq after reset");
        reg_read(EN_A, 8'h00, "R1 enable after reset");
        status_read(8'h00, "R1 status after reset");

        // R2 masked event recorded, no irq
        pulse(8'h04);
        check_bit(irq, 1'b0, "R2 masked event");
        status_read(8'h04, "R2 masked event recorded");

        // R3 held level sets once
        evt_in = 8'h20;
        repeat (5) tick();
        status_read(8'h20, "R3 held line first read");
        status_read(8'h00, "R3 held line no re-set");
        evt_in = 8'h00;
        tick();

        // R4 enable write raises irq immediately
        pulse(8'h02);
        check_bit(irq, 1'b0, "R4 before enable");
        reg_write(EN_A, 8'h02);
        check_bit(irq, 1'b1, "R4 after enable write");
        reg_read(EN_A, 8'h02, "R9 enable readback");
        check_bit(irq, 1'b1, "R4 irq holds");

        // R5 read releases irq, R6 clear
        status_read(8'h02, "R5 read of set bit");
        check_bit(irq, 1'b0, "R6 irq after clear");
        status_read(8'h00, "R6 status cleared");

        // R5 event in command cycle is reported
        rd_en     = 1'b1;
        rd_active = 1'b1;
        addr      = ST_A;
        evt_in    = 8'h08;
        exp_q.push_back(8'h08);
        tag_q.push_back("R5 command-cycle event");
        tick();
        rd_en  = 1'b0;
        evt_in = 8'h00;
        tick();
        rd_active = 1'b0;
        tick();
        tick();
        status_read(8'h00, "R5 command-cycle event not reposted");

        // R7 / R8 events during read
        reg_write(EN_A, 8'h42);
        pulse(8'h02);
        check_bit(irq, 1'b1, "R4 enabled event");
        rd_en     = 1'b1;
        rd_active = 1'b1;
        addr      = ST_A;
        exp_q.push_back(8'h02);
        tag_q.push_back("R5 read before deferral");
        tick();
        rd_en  = 1'b0;
        evt_in = 8'h42;
        tick();
        evt_in    = 8'h00;
        rd_active = 1'b0;
        check_bit(irq, 1'b0, "R5 irq low during read");
        tick();
        check_bit(irq, 1'b0, "R6 irq low after clear edge");
        tick();
        check_bit(irq, 1'b1, "R7 deferred event raises irq");
        status_read(8'h40, "R8 set bit dropped, new bit posted");

        // R9 status writes ignored
        pulse(8'h01);
        reg_write(ST_A, 8'hFF);
        tick();
        status_read(8'h01, "R9 status write ignored");
        reg_write(ST_A, 8'hFF);
        status_read(8'h00, "R9 status write after clear");

        // R10 soft reset
        reg_write(EN_A, 8'hFF);
        pulse(8'h10);
        check_bit(irq, 1'b1, "R10 irq before soft reset");
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        check_bit(irq, 1'b0, "R10 irq after soft reset");
        reg_read(EN_A, 8'h00, "R10 enable cleared");
        status_read(8'h00, "R10 status cleared");

        repeat (3) tick();
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d reads actual unchecked expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule